// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Selectable Write Behaviour

This block is a true two-port memory. Both ports share one clock, and each port can read or write any location on any cycle. Each port carries a data word and a set of parity bits, one parity bit per byte. The parity bits are stored with the data word and are returned with it. Each port has a registered output. A per-port parameter selects what that output shows on a cycle in which the same port writes: the word just written, the word the location held before the write, or its previous value unchanged.

The two ports may touch the same location in one cycle. The block gives defined results for this case, so a system can depend on them. If the writing port is in read-before-write mode, the other port sees the old stored word, and that word is valid. Under any other writing mode, the other port's output is marked invalid by a flag that is registered alongside the data. When both ports write the same location in one cycle, the stored word becomes undefined, and the block raises a one-cycle clash flag.

Top module: `dpram_wm`

## Requirements
- R1: A synchronous active-high reset clears both data outputs, both parity outputs, both invalid flags and the clash flag to zero. The memory contents are not reset.
- R2: When a port's enable is low at a clock edge, that port's data output, parity output and invalid flag keep their values.
- R3: When a port is enabled with write enable low, the word at the addressed location appears on that port's data and parity outputs one clock edge later.
- R4: A port whose mode parameter is 0 (write-first) presents the word it writes, data and parity, on its outputs one clock edge after the write.
- R5: A port whose mode parameter is 1 (read-first) presents the contents the location held before the write, and the location then holds the new word.
- R6: A port whose mode parameter is 2 (no-change) stores the written word. Its outputs and invalid flag keep their previous values.
- R7: The parity bits (PAR_W = DATA_W/8, one per byte) are written, stored, read and passed through exactly as the data bits are in every mode.
- R8: When a port reads a location that the other port writes in the same cycle, and the writer's mode is 1 (read-first), the reader shows the old stored word and its invalid flag is 0.
- R9: When a port loads its output while the other port writes the same location in the same cycle, and the writer's mode is 0 or 2, the loading port's invalid flag is 1 from the next edge. It is 0 on every other load.
- R10: When both ports write the same location in the same cycle, the clash flag is 1 for the following cycle and the stored word at that location is undefined until it is written again. The clash flag is 0 in every other case.
- R11: A word written through one port at one address is returned by a later read of that address through either port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A address |
| a_din | input | DATA_W | Port A write data |
| a_pin | input | PAR_W | Port A write parity |
| a_dout | output | DATA_W | Port A registered read data |
| a_pout | output | PAR_W | Port A registered read parity |
| a_bad | output | 1 | Port A output invalid (same-address write by port B) |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B address |
| b_din | input | DATA_W | Port B write data |
| b_pin | input | PAR_W | Port B write parity |
| b_dout | output | DATA_W | Port B registered read data |
| b_pout | output | PAR_W | Port B registered read parity |
| b_bad | output | 1 | Port B output invalid (same-address write by port A) |
| wr_clash | output | 1 | Both ports wrote the same address on the previous edge |

## Verification
Within one cycle, a write on one port can meet a read or a write on the other port at the same address. The result then depends on the writer's mode, so this is the case that matters most. The bench drives two instances with opposite mode mixes. Most random traffic goes to a four-word address window so that such meetings happen often, and directed cycles set up each same-address pairing on purpose. For every cycle, a bench model predicts the data, the parity, each invalid flag and the clash flag, and it marks locations left undefined by a double write so that they are not compared until they are rewritten.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Behaviour of a port's own output register on a cycle in which it writes.
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    // True when the output register takes a new value during an own write.
    function automatic logic loads_on_write(wmode_e m);
        return m != WM_NO_CHANGE;
    endfunction

    // True when a write in this mode makes a same-address read on the peer invalid.
    function automatic logic spoils_peer(wmode_e m);
        return m != WM_READ_FIRST;
    endfunction

    // Compact per-port access descriptor used by the collision logic.
    typedef struct packed {
        logic en;
        logic we;
    } access_t;

endpackage

// File: rtl/dpram_array.sv
module dpram_array #(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [WORD_W-1:0] wa_word,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [WORD_W-1:0] wb_word,
    input  logic [ADDR_W-1:0] ra_addr,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [WORD_W-1:0] ra_word,
    output logic [WORD_W-1:0] rb_word
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Pre-write contents; the output registers sample these on the same edge.
    assign ra_word = mem[ra_addr];
    assign rb_word = mem[rb_addr];

    // A double write to one address leaves it undefined; port B's write lands last here.
    always_ff @(posedge clk) begin
        if (wa_en) mem[wa_addr] <= wa_word;
        if (wb_en) mem[wb_addr] <= wb_word;
    end
endmodule

// File: rtl/dpram_collide.sv
module dpram_collide
    import dpram_pkg::*;
#(
    parameter int     ADDR_W = 6,
    parameter wmode_e MODE_A = WM_WRITE_FIRST,
    parameter wmode_e MODE_B = WM_READ_FIRST
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc_a,
    input  logic [ADDR_W-1:0] a_addr,
    input  access_t           acc_b,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              spoil_a,
    output logic              spoil_b,
    output logic              clash_q
);
    logic same_loc;

    assign same_loc = acc_a.en && acc_b.en && (a_addr == b_addr);
    assign spoil_a  = same_loc && acc_b.we && spoils_peer(MODE_B);
    assign spoil_b  = same_loc && acc_a.we && spoils_peer(MODE_A);

    always_ff @(posedge clk) begin
        if (rst) clash_q <= 1'b0;
        else     clash_q <= same_loc && acc_a.we && acc_b.we;
    end

    // R10
    clash_needs_writes_chk: assert property (@(posedge clk) disable iff (rst)
        clash_q |-> $past(acc_a.we && acc_b.we));
endmodule

// File: rtl/dpram_outport.sv
module dpram_outport
    import dpram_pkg::*;
#(
    parameter int     WORD_W = 18,
    parameter wmode_e MODE   = WM_WRITE_FIRST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [WORD_W-1:0] din_word,
    input  logic [WORD_W-1:0] old_word,
    input  logic              peer_spoil,
    output logic [WORD_W-1:0] dout_word,
    output logic              dout_bad
);
    logic [WORD_W-1:0] write_view;
    logic              load;

    generate
        if (MODE == WM_WRITE_FIRST) begin : g_pass
            assign write_view = din_word;
        end else begin : g_old
            assign write_view = old_word;
        end
    endgenerate

    assign load = en && (!we || loads_on_write(MODE));

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_word <= '0;
            dout_bad  <= 1'b0;
        end else if (load) begin
            dout_word <= we ? write_view : old_word;
            dout_bad  <= peer_spoil;
        end
    end

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout_word) && $stable(dout_bad));

    // R3
    read_loads_chk: assert property (@(posedge clk) disable iff (rst)
        en && !we |=> dout_word == $past(old_word));

    generate
        if (MODE == WM_WRITE_FIRST) begin : g_chk_wf
            // R4
            wf_shows_new_chk: assert property (@(posedge clk) disable iff (rst)
                en && we |=> dout_word == $past(din_word));
        end else if (MODE == WM_READ_FIRST) begin : g_chk_rf
            // R5
            rf_shows_old_chk: assert property (@(posedge clk) disable iff (rst)
                en && we |=> dout_word == $past(old_word));
        end else begin : g_chk_nc
            // R6
            nc_holds_chk: assert property (@(posedge clk) disable iff (rst)
                en && we |=> $stable(dout_word) && $stable(dout_bad));
        end
    endgenerate
endmodule

// File: rtl/dpram_wm.sv
module dpram_wm
    import dpram_pkg::*;
#(
    parameter int     DATA_W = 16,
    parameter int     PAR_W  = DATA_W / 8,
    parameter int     ADDR_W = 6,
    parameter wmode_e MODE_A = WM_WRITE_FIRST,
    parameter wmode_e MODE_B = WM_READ_FIRST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    input  logic [PAR_W-1:0]  a_pin,
    output logic [DATA_W-1:0] a_dout,
    output logic [PAR_W-1:0]  a_pout,
    output logic              a_bad,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    input  logic [PAR_W-1:0]  b_pin,
    output logic [DATA_W-1:0] b_dout,
    output logic [PAR_W-1:0]  b_pout,
    output logic              b_bad,
    output logic              wr_clash
);
    localparam int WORD_W = DATA_W + PAR_W;

    logic [WORD_W-1:0] a_word_in, b_word_in, a_old, b_old, a_word_q, b_word_q;
    logic              spoil_a, spoil_b;
    access_t           acc_a, acc_b;

    assign a_word_in = {a_pin, a_din};
    assign b_word_in = {b_pin, b_din};
    assign acc_a     = '{en: a_en, we: a_we};
    assign acc_b     = '{en: b_en, we: b_we};

    dpram_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wa_en   (a_en && a_we),
        .wa_addr (a_addr),
        .wa_word (a_word_in),
        .wb_en   (b_en && b_we),
        .wb_addr (b_addr),
        .wb_word (b_word_in),
        .ra_addr (a_addr),
        .rb_addr (b_addr),
        .ra_word (a_old),
        .rb_word (b_old)
    );

    dpram_collide #(.ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B)) u_collide (
        .clk     (clk),
        .rst     (rst),
        .acc_a   (acc_a),
        .a_addr  (a_addr),
        .acc_b   (acc_b),
        .b_addr  (b_addr),
        .spoil_a (spoil_a),
        .spoil_b (spoil_b),
        .clash_q (wr_clash)
    );

    dpram_outport #(.WORD_W(WORD_W), .MODE(MODE_A)) u_out_a (
        .clk        (clk),
        .rst        (rst),
        .en         (a_en),
        .we         (a_we),
        .din_word   (a_word_in),
        .old_word   (a_old),
        .peer_spoil (spoil_a),
        .dout_word  (a_word_q),
        .dout_bad   (a_bad)
    );

    dpram_outport #(.WORD_W(WORD_W), .MODE(MODE_B)) u_out_b (
        .clk        (clk),
        .rst        (rst),
        .en         (b_en),
        .we         (b_we),
        .din_word   (b_word_in),
        .old_word   (b_old),
        .peer_spoil (spoil_b),
        .dout_word  (b_word_q),
        .dout_bad   (b_bad)
    );

    assign {a_pout, a_dout} = a_word_q;
    assign {b_pout, b_dout} = b_word_q;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> a_word_q == '0 && b_word_q == '0 && !a_bad && !b_bad && !wr_clash);

    // R8
    rf_peer_valid_chk: assert property (@(posedge clk) disable iff (rst)
        a_en && !a_we && b_en && b_we && a_addr == b_addr && MODE_B == WM_READ_FIRST
        |=> !a_bad && a_word_q == $past(a_old));

    // R9
    peer_spoiled_chk: assert property (@(posedge clk) disable iff (rst)
        b_en && !b_we && a_en && a_we && a_addr == b_addr && MODE_A != WM_READ_FIRST
        |=> b_bad);

    // R10
    double_write_flag_chk: assert property (@(posedge clk) disable iff (rst)
        a_en && a_we && b_en && b_we && a_addr == b_addr |=> wr_clash);
endmodule

// File: tb/dpram_wm_tb.sv
module dpram_wm_tb;
    import dpram_pkg::*;

    localparam int DW = 16;
    localparam int PW = 2;
    localparam int AW = 6;
    localparam int WW = DW + PW;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic [WW-1:0] q;
        bit            k;
        bit            bad;
        string         tag;
    } pexp_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          a_en, a_we, b_en, b_we;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_din, b_din;
    logic [PW-1:0] a_pin, b_pin;

    logic [DW-1:0] a_dout [2];
    logic [DW-1:0] b_dout [2];
    logic [PW-1:0] a_pout [2];
    logic [PW-1:0] b_pout [2];
    logic          a_bad [2];
    logic          b_bad [2];
    logic          clash [2];

    // Instance 0: A write-first, B read-first. Instance 1: A no-change, B write-first.
    int mode_a [2] = '{0, 2};
    int mode_b [2] = '{1, 0};

    dpram_wm #(.DATA_W(DW), .PAR_W(PW), .ADDR_W(AW),
               .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST)) u_dut (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(a_dout[0]), .a_pout(a_pout[0]), .a_bad(a_bad[0]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(b_dout[0]), .b_pout(b_pout[0]), .b_bad(b_bad[0]),
        .wr_clash(clash[0]));

    dpram_wm #(.DATA_W(DW), .PAR_W(PW), .ADDR_W(AW),
               .MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST)) u_dut_alt (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(a_dout[1]), .a_pout(a_pout[1]), .a_bad(a_bad[1]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(b_dout[1]), .b_pout(b_pout[1]), .b_bad(b_bad[1]),
        .wr_clash(clash[1]));

    // Reference model state
    logic [WW-1:0] mref  [2][DEPTH];
    bit            kref  [2][DEPTH];
    int            wr_by [2][DEPTH];
    pexp_t         ea [2];
    pexp_t         eb [2];
    bit            eclash [2];

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    task automatic check(bit ok, string tag, string what, int inst, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s inst%0d %s actual=%0h expected=%0h", tag, inst, what, act, exp);
        end
    endtask

    function automatic pexp_t port_next(pexp_t cur, int i, int me, bit en, bit we,
                                        logic [AW-1:0] addr, logic [WW-1:0] word, int mode,
                                        bit p_en, bit p_we, logic [AW-1:0] p_addr, int p_mode);
        pexp_t n = cur;
        bit    hit = p_en && p_we && (p_addr == addr);
        bit    spoil = hit && (p_mode != 1);
        if (!en) begin
            n.tag = "R2";
        end else if (!we) begin
            n.q = mref[i][addr];
            n.k = kref[i][addr];
            n.bad = spoil;
            if (hit && p_mode == 1)           n.tag = "R8";
            else if (wr_by[i][addr] == 1 - me) n.tag = "R11";
            else                               n.tag = "R3";
        end else begin
            case (mode)
                0: begin n.q = word; n.k = 1'b1; n.bad = spoil; n.tag = "R4"; end
                1: begin n.q = mref[i][addr]; n.k = kref[i][addr]; n.bad = spoil; n.tag = "R5"; end
                default: n.tag = "R6";
            endcase
        end
        return n;
    endfunction

    task automatic step_model();
        for (int i = 0; i < 2; i++) begin
            pexp_t na, nb;
            na = port_next(ea[i], i, 0, a_en, a_we, a_addr, {a_pin, a_din}, mode_a[i],
                           b_en, b_we, b_addr, mode_b[i]);
            nb = port_next(eb[i], i, 1, b_en, b_we, b_addr, {b_pin, b_din}, mode_b[i],
                           a_en, a_we, a_addr, mode_a[i]);
            ea[i] = na;
            eb[i] = nb;
            eclash[i] = a_en && a_we && b_en && b_we && (a_addr == b_addr);
            if (a_en && a_we) begin
                mref[i][a_addr] = {a_pin, a_din}; kref[i][a_addr] = 1'b1; wr_by[i][a_addr] = 0;
            end
            if (b_en && b_we) begin
                mref[i][b_addr] = {b_pin, b_din}; kref[i][b_addr] = 1'b1; wr_by[i][b_addr] = 1;
            end
            if (eclash[i]) kref[i][a_addr] = 1'b0;
        end
    endtask

    task automatic check_port(int i, string pn, pexp_t e, logic [DW-1:0] d, logic [PW-1:0] p, logic bd);
        check(bd === e.bad, (e.tag == "R1") ? "R1" : "R9", {pn, " invalid flag"}, i, 32'(bd), 32'(e.bad));
        if (e.k && !e.bad) begin
            check(d === e.q[DW-1:0], e.tag, {pn, " data"}, i, 32'(d), 32'(e.q[DW-1:0]));
            check(p === e.q[WW-1:DW], (e.tag == "R1") ? "R1" : "R7", {pn, " parity"}, i,
                  32'(p), 32'(e.q[WW-1:DW]));
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < 2; i++) begin
            check_port(i, "A", ea[i], a_dout[i], a_pout[i], a_bad[i]);
            check_port(i, "B", eb[i], b_dout[i], b_pout[i], b_bad[i]);
            check(clash[i] === eclash[i], "R10", "clash flag", i, 32'(clash[i]), 32'(eclash[i]));
        end
    endtask

    task automatic cyc(bit ae, bit aw, int aa, bit be, bit bw, int ba);
        @(negedge clk);
        check_all();
        a_en = ae; a_we = aw; a_addr = AW'(aa); a_din = DW'($urandom); a_pin = PW'($urandom);
        b_en = be; b_we = bw; b_addr = AW'(ba); b_din = DW'($urandom); b_pin = PW'($urandom);
        step_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst = 1'b1;
        a_en = 0; a_we = 0; a_addr = '0; a_din = '0; a_pin = '0;
        b_en = 0; b_we = 0; b_addr = '0; b_din = '0; b_pin = '0;
        for (int i = 0; i < 2; i++) begin
            ea[i] = '{q: '0, k: 1'b1, bad: 1'b0, tag: "R1"};
            eb[i] = '{q: '0, k: 1'b1, bad: 1'b0, tag: "R1"};
            eclash[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                kref[i][j] = 1'b0; wr_by[i][j] = -1; mref[i][j] = '0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: first comparison sees the reset state; R11: fill through both ports
        for (int k = 0; k < DEPTH / 2; k++) cyc(1, 1, k, 1, 1, k + DEPTH / 2);
        // R11 / R3 / R7: cross reads
        for (int k = 0; k < DEPTH / 2; k++) cyc(1, 0, k + DEPTH / 2, 1, 0, k);
        // R2: both disabled, outputs hold
        cyc(0, 1, 3, 0, 1, 4);
        cyc(0, 0, 9, 0, 0, 10);
        // R4 / R5 / R6: own writes at distinct addresses
        cyc(1, 1, 12, 1, 1, 13);
        cyc(1, 0, 13, 1, 0, 12);
        // R9: A writes, B reads same address
        cyc(1, 1, 5, 1, 0, 5);
        // R8 (inst 0) / R9 (inst 1): B writes, A reads same address
        cyc(1, 0, 6, 1, 1, 6);
        // R9 on own-writing reader
        cyc(1, 1, 8, 1, 1, 9);
        // R10: double write, then rewrite
        cyc(1, 1, 7, 1, 1, 7);
        cyc(1, 0, 7, 1, 0, 7);
        cyc(1, 1, 7, 0, 0, 0);
        cyc(1, 0, 7, 1, 0, 7);
        cyc(0, 0, 0, 0, 0, 0);

        // Constrained random traffic, mostly inside a four-word window
        for (int n = 0; n < 3000; n++) begin
            bit narrow = ($urandom % 2) == 0;
            int aa = narrow ? int'($urandom % 4) : int'($urandom % DEPTH);
            int ba = narrow ? int'($urandom % 4) : int'($urandom % DEPTH);
            cyc(($urandom % 5) != 0, ($urandom % 2) == 0, aa,
                ($urandom % 5) != 0, ($urandom % 2) == 0, ba);
        end

        cyc(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check_all();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule